// File: doc/BRIEF.md
# Thresholded Perceptron Dot-Product Unit

This block classifies one input vector at a time as a single-layer perceptron. It receives a stream of weight and activation pairs, one pair per accepted beat. Each operand is a signed 8-bit fixed-point value. A single signed multiply-accumulate engine is reused for every element of the vector. When the closing beat arrives, the block adds a signed bias to the running sum and applies a hard step at zero. The result is a one-bit class decision.

A pair in which either operand is zero is not multiplied and not accumulated. Such a pair is counted as skipped, and that count is reported with the decision. The caller drives pairs with `inValid`, observes `inReady`, and marks the final pair with `inLast`. One cycle after that final pair is accepted, the block shows the decision and the skip count for exactly one cycle. It then starts the next vector from a cleared sum and a cleared count. The bias comes from a plain input that the caller holds steady while the result is shown.

Top module: `percep_unit`

## Requirements
- R1: After synchronous active-high reset, `resValid` is 0 and `inReady` is 1.
- R2: The decision is computed from the sum of the signed products `inWeight*inAct`, taken over every beat accepted since the previous result, up to and including the beat carrying `inLast`.
- R3: The signed 24-bit `biasIn` is added to the accumulated sum before the threshold is applied.
- R4: `resClass` is 1 only when sum plus bias is strictly greater than zero. A total of exactly zero, or any negative total, gives 0.
- R5: An accepted pair whose weight or activation equals zero adds nothing to the accumulator.
- R6: `resSkips` equals the number of accepted pairs of the vector in which the weight, the activation, or both were zero.
- R7: `resValid` rises in the cycle after a beat with `inValid`, `inReady` and `inLast` all high. It lasts exactly one cycle, and `inReady` is 0 during that cycle.
- R8: After a result, the accumulator and the skip counter start from zero, so each vector's decision and count depend only on its own pairs.
- R9: A beat with `inValid` low changes neither the sum nor the count, and does not end the vector, even when `inLast` is high.
- R10: The sum does not overflow for vectors of up to 256 pairs of full-scale operands, including 256 pairs of -128 times -128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | A weight and activation pair is offered |
| inReady | output | 1 | The block can take a pair this cycle |
| inWeight | input | 8 | Signed weight element |
| inAct | input | 8 | Signed activation element |
| inLast | input | 1 | This pair closes the vector |
| biasIn | input | 24 | Signed bias, held stable while the result is shown |
| resValid | output | 1 | Decision and skip count are valid this cycle |
| resClass | output | 1 | Class decision: 1 when sum plus bias is above zero |
| resSkips | output | 9 | Number of zero-operand pairs in the vector |

## Verification
The bench drives bias values that make the total land exactly on zero, one above it and one below it. A design that used greater-or-equal, or that dropped or double-counted the bias, gives the wrong class on at least one of these cases. Full-scale vectors of 256 pairs, with products of both signs, expose an accumulator that is too narrow or that sign-extends wrongly; such a design wraps and flips the decision. Vectors made entirely of zero pairs, back-to-back vectors, and invalid beats carrying garbage data and a stray last marker are also driven. These catch a skip counter or accumulator that is not cleared, that counts wrongly, that takes idle beats, or that ends a vector early.

// File: rtl/percep_pkg.sv
package percep_pkg;

  localparam int DATA_W  = 8;
  localparam int ACC_W   = 24;
  localparam int MAX_LEN = 256;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  // Strobes from the control module to the datapath, one cycle each.
  typedef struct packed {
    logic accEn;   // add the current product to the sum
    logic skipInc; // count the current pair as skipped
    logic clrAll;  // return sum and count to zero
  } strobes_t;

endpackage

// File: rtl/percep_ctrl.sv
module percep_ctrl
  import percep_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inValid,
  input  logic          inLast,
  input  logic [DW-1:0] inWeight,
  input  logic [DW-1:0] inAct,
  output logic          inReady,
  output logic          resValid,
  output strobes_t      strb
);

  logic doneQ;
  logic accept;
  logic zeroPair;

  assign inReady  = !doneQ;
  assign accept   = inValid && inReady;
  assign zeroPair = (inWeight == '0) || (inAct == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      doneQ <= 1'b0;
    end else begin
      doneQ <= accept && inLast;
    end
  end

  always_comb begin
    strb.accEn   = accept && !zeroPair;
    strb.skipInc = accept && zeroPair;
    strb.clrAll  = doneQ;
  end

  assign resValid = doneQ;

endmodule

// File: rtl/percep_datapath.sv
module percep_datapath
  import percep_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ACC_W,
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  strobes_t      strb,
  input  logic [DW-1:0] inWeight,
  input  logic [DW-1:0] inAct,
  input  logic [AW-1:0] biasIn,
  output logic          decide,
  output logic [CW-1:0] skipCnt
);

  localparam int PW = 2 * DW;

  logic signed [PW-1:0] prod;
  logic signed [AW-1:0] prodExt;
  logic signed [AW-1:0] accQ;
  logic signed [AW:0]   biased;
  logic        [CW-1:0] skipQ;

  assign prod    = $signed(inWeight) * $signed(inAct);
  assign prodExt = {{(AW - PW){prod[PW-1]}}, prod};

  always_ff @(posedge clk) begin
    if (rst || strb.clrAll) begin
      accQ  <= '0;
      skipQ <= '0;
    end else begin
      if (strb.accEn) begin
        accQ <= accQ + prodExt;
      end
      if (strb.skipInc) begin
        skipQ <= skipQ + 1'b1;
      end
    end
  end

  // One extra bit so that sum plus bias cannot wrap.
  assign biased  = {accQ[AW-1], accQ} + {biasIn[AW-1], biasIn};
  assign decide  = !biased[AW] && (biased != '0);
  assign skipCnt = skipQ;

endmodule

// File: rtl/percep_unit.sv
module percep_unit
  import percep_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ACC_W,
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inValid,
  output logic          inReady,
  input  logic [DW-1:0] inWeight,
  input  logic [DW-1:0] inAct,
  input  logic          inLast,
  input  logic [AW-1:0] biasIn,
  output logic          resValid,
  output logic          resClass,
  output logic [CW-1:0] resSkips
);

  strobes_t strb;
  logic     decide;
  logic [CW-1:0] skipCnt;

  percep_ctrl #(.DW(DW)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .inLast   (inLast),
    .inWeight (inWeight),
    .inAct    (inAct),
    .inReady  (inReady),
    .resValid (resValid),
    .strb     (strb)
  );

  percep_datapath #(.DW(DW), .AW(AW), .CW(CW)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strb     (strb),
    .inWeight (inWeight),
    .inAct    (inAct),
    .biasIn   (biasIn),
    .decide   (decide),
    .skipCnt  (skipCnt)
  );

  assign resClass = resValid && decide;
  assign resSkips = skipCnt;

endmodule

// File: rtl/percep_unit_chk.sv
module percep_unit_chk (
  input logic clk,
  input logic rst,
  input logic inValid,
  input logic inReady,
  input logic inLast,
  input logic resValid
);

  // R7: a result follows the accepted closing beat
  a_r7_result_after_last: assert property (@(posedge clk) disable iff (rst)
    (inValid && inReady && inLast) |=> resValid);

  // R7: the result lasts a single cycle
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
    resValid |=> !resValid);

  // R7: no pair is taken while the result is shown
  a_r7_ready_low: assert property (@(posedge clk) disable iff (rst)
    resValid |-> !inReady);

  // R9: a result only comes from an accepted closing beat
  a_r9_no_spurious_result: assert property (@(posedge clk) disable iff (rst)
    resValid |-> $past(inValid && inReady && inLast));

  // R1: reset leaves no result pending
  a_r1_reset_idle: assert property (@(posedge clk)
    $past(rst) |-> (!resValid && inReady));

endmodule

bind percep_unit percep_unit_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .inValid  (inValid),
  .inReady  (inReady),
  .inLast   (inLast),
  .resValid (resValid)
);

// File: tb/percep_unit_test.sv
module percep_unit_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [7:0]  inWeight = '0;
  logic [7:0]  inAct = '0;
  logic        inLast = 1'b0;
  logic [23:0] biasIn = '0;
  logic        resValid;
  logic        resClass;
  logic [8:0]  resSkips;

  int checks = 0;
  int errors = 0;

  logic signed [7:0] wv [256];
  logic signed [7:0] xv [256];

  always #10 clk = ~clk;

  percep_unit uut (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
    .inWeight(inWeight), .inAct(inAct), .inLast(inLast), .biasIn(biasIn),
    .resValid(resValid), .resClass(resClass), .resSkips(resSkips)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint expSum(input int n);
    longint s = 0;
    for (int i = 0; i < n; i++) s += longint'(wv[i]) * longint'(xv[i]);
    return s;
  endfunction

  function automatic int expSkips(input int n);
    int c = 0;
    for (int i = 0; i < n; i++) if (wv[i] == 0 || xv[i] == 0) c++;
    return c;
  endfunction

  // Drives n pairs from wv/xv, with optional idle beats carrying garbage.
  task automatic runVector(input int n, input longint bias, input bit gaps, input string tag);
    longint tot;
    bit expClass;
    int expSk;
    biasIn = 24'(bias);
    for (int i = 0; i < n; i++) begin
      if (gaps && ($urandom % 4 == 0)) begin
        @(negedge clk);
        inValid  = 1'b0;
        inWeight = 8'($urandom);
        inAct    = 8'($urandom);
        inLast   = 1'($urandom);
        @(posedge clk);
      end
      @(negedge clk);
      inValid  = 1'b1;
      inWeight = wv[i];
      inAct    = xv[i];
      inLast   = (i == n - 1);
      @(posedge clk);
    end
    @(negedge clk);
    inValid = 1'b0;
    inLast  = 1'b0;
    tot      = expSum(n) + bias;
    expClass = (tot > 0);
    expSk    = expSkips(n);
    // R7: result one cycle after the closing beat, ready low
    check(resValid === 1'b1, {"R7 resValid ", tag}, resValid, 1);
    check(inReady === 1'b0, {"R7 inReady ", tag}, inReady, 0);
    // R2 R3 R4 R5 R10: decision from biased sum
    check(resClass === expClass, {"R2/R4 class ", tag}, resClass, expClass);
    // R6: skip count
    check(resSkips === 9'(expSk), {"R6 skips ", tag}, resSkips, expSk);
    @(negedge clk);
    check(resValid === 1'b0, {"R7 pulse ", tag}, resValid, 0);
  endtask

  task automatic finishRun;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check(resValid === 1'b0, "R1 resValid", resValid, 0);
    check(inReady === 1'b1, "R1 inReady", inReady, 1);
    rst = 1'b0;

    // R4: single product, bias brings total to exactly zero -> 0
    wv[0] = 8'sd6; xv[0] = -8'sd7;
    runVector(1, 42, 0, "R4 zero total");
    // R3: bias one above -> 1
    runVector(1, 43, 0, "R3 bias plus one");
    // R3: bias one below -> 0
    runVector(1, 41, 0, "R3 bias minus one");

    // R5 R6: all pairs zero, positive bias -> 1, all skipped
    for (int i = 0; i < 10; i++) begin
      wv[i] = (i % 2) ? 8'sd0 : 8'sd99;
      xv[i] = (i % 3) ? 8'sd0 : -8'sd50;
      if (i % 2 == 0 && i % 3 == 0) wv[i] = 8'sd0;
    end
    runVector(10, 1, 0, "R5 all zero pos bias");
    // R5: same vector with zero bias -> 0
    runVector(10, 0, 0, "R5 all zero no bias");

    // R10: 256 full-scale positive products, bias cancels exactly
    for (int i = 0; i < 256; i++) begin wv[i] = -8'sd128; xv[i] = -8'sd128; end
    runVector(256, -4194304, 0, "R10 full scale zero");
    runVector(256, -4194303, 0, "R10 full scale plus");
    // R10: 256 negative products against a large positive bias
    for (int i = 0; i < 256; i++) begin wv[i] = -8'sd128; xv[i] = 8'sd127; end
    runVector(256, 4161537, 0, "R10 negative plus");
    runVector(256, 4161536, 0, "R10 negative zero");

    // R8 R9: back-to-back random vectors with idle garbage beats
    for (int v = 0; v < 60; v++) begin
      int n;
      longint b;
      n = 1 + int'($urandom % 40);
      for (int i = 0; i < n; i++) begin
        wv[i] = ($urandom % 4 == 0) ? 8'sd0 : 8'($urandom);
        xv[i] = ($urandom % 4 == 0) ? 8'sd0 : 8'($urandom);
      end
      b = expSum(n);
      case ($urandom % 3)
        0: b = -b;
        1: b = -b + 1;
        default: b = longint'($signed(16'($urandom)));
      endcase
      runVector(n, b, 1, "R8/R9 random");
    end

    finishRun();
  end

endmodule